// File: doc/BRIEF.md
# Chainable SPI Configuration Slave

This block is the serial control port of an eight-channel isolated digital input front end. It recovers SPI frames from oversampled SCLK, NSS and MOSI pins in the system clock domain. Software uses it to read the live channel levels and to set a two-bit filter mode and a two-bit filter delay for each channel. Every byte of a packet sits in its own NSS-low window. A packet has three bytes: a control byte, a register address and a data byte. On a read, the slave returns the data byte on MISO.

Up to sixteen slaves can share one master. Each slave forwards the master's stream on a pass-through output to the next slave. On the way it lowers the chain ID field of the control byte by one, so only the slave that receives ID 0 answers. A write with the broadcast flag reaches every slave. A rising SCLK while NSS is high returns the packet state machine to the control-byte stage. A master that has lost framing uses this to recover.

Top module: `spi_chain_slave`

## Requirements
- R1: Each byte is shifted MSB first on exactly eight rising SCLK edges inside one NSS-low window. The NSS rise that ends a byte moves the packet on, in order, from control to address to data and then back to control.
- R2: Control byte layout: bit 7 is the broadcast flag, bit 6 selects read (1) or write (0), and bits 5:4 are not used. Bits 3:0 hold the chain ID with its bit order reversed: bit 3 carries ID bit 0 and bit 0 carries ID bit 3.
- R3: A slave applies a packet when the chain ID it receives is 0. A write with the broadcast flag set is also applied, whatever the ID. The broadcast flag has no effect on a read.
- R4: The MISO enable output is high only while NSS is low during the data byte of an applied read. It is low at every other time, including the whole of any write, and MISO then counts as high-impedance.
- R5: Address 0 returns the channel status input and ignores writes. Addresses 1 and 2 are the filter mode bytes: filt_mode_o[7:0] comes from address 1 and filt_mode_o[15:8] from address 2. Addresses 3 and 4 feed filt_delay_o[7:0] and filt_delay_o[15:8] in the same way. Channel n uses bits [2n+1:2n].
- R6: A read of any address above 4 returns 0x00. A write to any address above 4 changes no output.
- R7: sdi_thru_o repeats MOSI bit for bit. The one exception is the chain ID of each control byte, which goes out as (ID − 1) mod 16 in the same reversed layout.
- R8: A rising SCLK while NSS is high returns the slave to the control-byte stage, from any stage.
- R9: If NSS rises after fewer than eight clocks, the slave drops the packet and its target register keeps its value. Every later byte is ignored until a resynchronization as in R8.
- R10: A data byte with more than eight clocks commits nothing. It also drops the slave out of framing, as in R9.
- R11: A write takes effect on the NSS rise that ends a data byte of exactly eight clocks.
- R12: After reset, both configuration outputs are zero, MISO enable is low and the slave waits for a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI clock from the master |
| nss_i | input | 1 | Active-low byte select |
| mosi_i | input | 1 | Serial data from the master |
| status_i | input | 8 | Current channel levels, read at address 0 |
| miso_o | output | 1 | Serial read data, valid while miso_oe_o is high |
| miso_oe_o | output | 1 | MISO driver enable; low means high-impedance |
| sdi_thru_o | output | 1 | MOSI forwarded to the next slave with the chain ID lowered |
| filt_mode_o | output | 16 | Two mode bits per channel |
| filt_delay_o | output | 16 | Two delay bits per channel |

## Verification
The assertions assume that the master never moves SCLK and NSS in the same system cycle. They also assume that each SCLK level lasts several system clocks, so that every edge is seen once after synchronization. The bench holds each SCLK phase and each NSS gap for six or more clocks. It sets MOSI only while SCLK is low and changes NSS only with SCLK low. Broken framing comes only from short or long data and address bytes, and each is followed by a deliberate SCLK pulse with NSS high.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 4;

  typedef enum logic [1:0] {
    ST_CTRL,
    ST_ADDR,
    ST_DATA,
    ST_LOST
  } pkt_stage_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic nss_i,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic nss_lvl_o,
  output logic nss_rise_o,
  output logic nss_fall_o,
  output logic mosi_lvl_o
);
  localparam int LVL = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   sclk_sh, nss_sh;
  logic [SYNC_STAGES-1:0] mosi_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sh <= '0;
      nss_sh  <= '1;
      mosi_sh <= '0;
    end else begin
      sclk_sh <= {sclk_sh[SYNC_STAGES-1:0], sclk_i};
      nss_sh  <= {nss_sh[SYNC_STAGES-1:0], nss_i};
      mosi_sh <= {mosi_sh[SYNC_STAGES-2:0], mosi_i};
    end
  end

  assign sclk_rise_o = sclk_sh[LVL] & ~sclk_sh[SYNC_STAGES];
  assign sclk_fall_o = ~sclk_sh[LVL] & sclk_sh[SYNC_STAGES];
  assign nss_lvl_o   = nss_sh[LVL];
  assign nss_rise_o  = nss_sh[LVL] & ~nss_sh[SYNC_STAGES];
  assign nss_fall_o  = ~nss_sh[LVL] & nss_sh[SYNC_STAGES];
  assign mosi_lvl_o  = mosi_sh[LVL];
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              nss_lvl_i,
  input  logic              nss_rise_i,
  input  logic              nss_fall_i,
  input  logic              mosi_lvl_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic              wr_commit_o,
  output logic              rd_load_o,
  output logic              rd_active_o,
  output logic              thru_o
);
  localparam int CNT_W   = $clog2(BYTE_W + 2);
  localparam int CNT_MAX = BYTE_W + 1;

  pkt_stage_e        stage_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              bcast_q, rd_q, borrow_q;
  logic [ID_W-1:0]   id_q;
  logic              resync, capture, byte_ok, id_zone, selected;

  assign resync   = sclk_rise_i & nss_lvl_i;
  assign capture  = sclk_rise_i & ~nss_lvl_i;
  assign byte_ok  = (bit_cnt_q == CNT_W'(BYTE_W));
  // id field occupies the last ID_W bits of the control byte
  assign id_zone  = (stage_q == ST_CTRL) && (bit_cnt_q >= CNT_W'(BYTE_W - ID_W))
                    && (bit_cnt_q < CNT_W'(BYTE_W));
  assign selected = (id_q == '0) | (bcast_q & ~rd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= ST_CTRL;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      bcast_q   <= 1'b0;
      rd_q      <= 1'b0;
      id_q      <= '0;
      addr_o    <= '0;
      borrow_q  <= 1'b1;
    end else if (resync) begin
      stage_q   <= ST_CTRL;
      bit_cnt_q <= '0;
    end else begin
      if (nss_fall_i) begin
        bit_cnt_q <= '0;
        borrow_q  <= 1'b1;
      end else if (capture) begin
        shreg_q <= {shreg_q[BYTE_W-2:0], mosi_lvl_i};
        if (bit_cnt_q != CNT_W'(CNT_MAX)) bit_cnt_q <= bit_cnt_q + 1'b1;
        if (id_zone) borrow_q <= borrow_q & ~mosi_lvl_i;
      end
      if (nss_rise_i) begin
        unique case (stage_q)
          ST_CTRL: if (byte_ok) begin
            stage_q <= ST_ADDR;
            bcast_q <= shreg_q[7];
            rd_q    <= shreg_q[6];
            id_q    <= {shreg_q[0], shreg_q[1], shreg_q[2], shreg_q[3]};
          end else stage_q <= ST_LOST;
          ST_ADDR: if (byte_ok) begin
            stage_q <= ST_DATA;
            addr_o  <= shreg_q;
          end else stage_q <= ST_LOST;
          ST_DATA: stage_q <= byte_ok ? ST_CTRL : ST_LOST;
          ST_LOST: stage_q <= ST_LOST;
        endcase
      end
    end
  end

  assign byte_o      = shreg_q;
  assign wr_commit_o = nss_rise_i && (stage_q == ST_DATA) && byte_ok && !rd_q && selected && !resync;
  assign rd_load_o   = nss_rise_i && (stage_q == ST_ADDR) && byte_ok;
  assign rd_active_o = (stage_q == ST_DATA) && !nss_lvl_i && rd_q && (id_q == '0);
  assign thru_o      = mosi_lvl_i ^ (id_zone & borrow_q);

  assert_resync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync |=> (stage_q == ST_CTRL));
  assert_commit_after_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(!nss_lvl_i));
  assert_no_overrun_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nss_rise_i && bit_cnt_q > CNT_W'(BYTE_W)) |-> !wr_commit_o);
  assert_lost_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == ST_LOST && !resync) |=> (stage_q == ST_LOST));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_chain_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH-1:0]   status_i,
  input  logic                wr_commit_i,
  input  logic [BYTE_W-1:0]   wr_addr_i,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic                rd_load_i,
  input  logic                shift_i,
  output logic [2*NUM_CH-1:0] mode_o,
  output logic [2*NUM_CH-1:0] delay_o,
  output logic                tx_bit_o
);
  localparam int FIELD_BYTES = (2 * NUM_CH) / BYTE_W;
  localparam int NREG        = 2 * FIELD_BYTES;

  logic [BYTE_W-1:0] cfg_w [NREG];
  logic [BYTE_W-1:0] rd_val, tx_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] MY_ADDR = BYTE_W'(i + 1);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (wr_commit_i && wr_addr_i == MY_ADDR) q <= byte_i;
    end
    assign cfg_w[i] = q;
  end

  for (genvar b = 0; b < FIELD_BYTES; b++) begin : g_out
    assign mode_o[BYTE_W*b +: BYTE_W]  = cfg_w[b];
    assign delay_o[BYTE_W*b +: BYTE_W] = cfg_w[FIELD_BYTES + b];
  end

  always_comb begin
    rd_val = '0;
    if (byte_i == '0) rd_val = BYTE_W'(status_i);
    for (int i = 0; i < NREG; i++)
      if (byte_i == BYTE_W'(i + 1)) rd_val = cfg_w[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tx_q <= '0;
    else if (rd_load_i) tx_q <= rd_val;
    else if (shift_i)   tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
  end
  assign tx_bit_o = tx_q[BYTE_W-1];

  assert_mode_needs_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(wr_commit_i && wr_addr_i >= 1 && wr_addr_i <= FIELD_BYTES));
  assert_delay_needs_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(delay_o) |-> $past(wr_commit_i && wr_addr_i > FIELD_BYTES && wr_addr_i <= NREG));
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                nss_i,
  input  logic                mosi_i,
  input  logic [NUM_CH-1:0]   status_i,
  output logic                miso_o,
  output logic                miso_oe_o,
  output logic                sdi_thru_o,
  output logic [2*NUM_CH-1:0] filt_mode_o,
  output logic [2*NUM_CH-1:0] filt_delay_o
);
  logic sclk_rise, sclk_fall, nss_lvl, nss_rise, nss_fall, mosi_lvl;
  logic wr_commit, rd_load, rd_active, tx_bit;
  logic [BYTE_W-1:0] byte_w, addr_w;

  spi_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .nss_i, .mosi_i,
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .nss_lvl_o(nss_lvl), .nss_rise_o(nss_rise), .nss_fall_o(nss_fall),
    .mosi_lvl_o(mosi_lvl)
  );

  spi_frame_ctl u_frame (
    .clk_i, .rst_ni,
    .sclk_rise_i(sclk_rise), .nss_lvl_i(nss_lvl), .nss_rise_i(nss_rise),
    .nss_fall_i(nss_fall), .mosi_lvl_i(mosi_lvl),
    .byte_o(byte_w), .addr_o(addr_w), .wr_commit_o(wr_commit),
    .rd_load_o(rd_load), .rd_active_o(rd_active), .thru_o(sdi_thru_o)
  );

  spi_reg_bank #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i, .rst_ni, .status_i,
    .wr_commit_i(wr_commit), .wr_addr_i(addr_w), .byte_i(byte_w),
    .rd_load_i(rd_load), .shift_i(sclk_fall & rd_active),
    .mode_o(filt_mode_o), .delay_o(filt_delay_o), .tx_bit_o(tx_bit)
  );

  assign miso_oe_o = rd_active;
  assign miso_o    = rd_active & tx_bit;

  assert_oe_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nss_lvl |-> !miso_oe_o);
endmodule

// File: tb/spi_chain_slave_test.sv
module spi_chain_slave_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, sclk = 1'b0, nss = 1'b1, mosi = 1'b0;
  logic [7:0] status = 8'h00;
  logic miso, oe, thru;
  logic [15:0] mode, dly;

  spi_chain_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .nss_i(nss), .mosi_i(mosi),
    .status_i(status), .miso_o(miso), .miso_oe_o(oe), .sdi_thru_o(thru),
    .filt_mode_o(mode), .filt_delay_o(dly)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] mdl [1:4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] mk_ctl(input bit bc, input bit rd, input logic [3:0] id);
    return {bc, rd, 2'b00, id[0], id[1], id[2], id[3]};
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'd0) return status;
    if (a >= 8'd1 && a <= 8'd4) return mdl[a[2:0]];
    return 8'h00;
  endfunction

  task automatic send_byte(input logic [7:0] b, input int nclk,
                           output logic [7:0] rx, output logic [7:0] fw, output int oe_cnt);
    rx = '0; fw = '0; oe_cnt = 0;
    nss = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < 8) ? b[7-i] : 1'b0;
      wait_clk(6);
      if (i < 8) begin rx[7-i] = miso; fw[7-i] = thru; end
      if (oe) oe_cnt++;
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
    end
    wait_clk(6);
    nss = 1'b1;
    wait_clk(8);
  endtask

  task automatic packet(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d, input int dclk,
                        output logic [7:0] rd, output logic [7:0] fw_c, output logic [7:0] fw_a,
                        output int oe_hdr, output int oe_dat);
    logic [7:0] r0, r1; int o0, o1;
    logic [7:0] fw_d;
    send_byte(c, 8, r0, fw_c, o0);
    send_byte(a, 8, r1, fw_a, o1);
    send_byte(d, dclk, rd, fw_d, oe_dat);
    oe_hdr = o0 + o1;
  endtask

  task automatic resync();
    nss = 1'b1;
    sclk = 1'b1;
    wait_clk(6);
    sclk = 1'b0;
    wait_clk(6);
  endtask

  task automatic chk_cfg(input string req);
    chk(mode == {mdl[2], mdl[1]}, req, mode, {mdl[2], mdl[1]});
    chk(dly == {mdl[4], mdl[3]}, req, dly, {mdl[4], mdl[3]});
  endtask

  // simple full packet with model update
  task automatic do_pkt(input bit bc, input bit rd, input logic [3:0] id,
                        input logic [7:0] a, input logic [7:0] d, input string req);
    logic [7:0] r, fc, fa; int oh, od;
    bit sel;
    logic [7:0] er;
    er = exp_read(a);
    packet(mk_ctl(bc, rd, id), a, d, 8, r, fc, fa, oh, od);
    sel = (id == 4'd0) || (bc && !rd);
    chk(oh == 0, {req, " R4 hdr oe"}, oh, 0);
    chk(fc == mk_ctl(bc, rd, id - 4'd1), {req, " R7 fwd ctl"}, fc, mk_ctl(bc, rd, id - 4'd1));
    chk(fa == a, {req, " R7 fwd addr"}, fa, a);
    if (rd) begin
      chk(od == ((id == 4'd0) ? 8 : 0), {req, " R4/R3 data oe"}, od, (id == 4'd0) ? 8 : 0);
      if (id == 4'd0) chk(r == er, {req, " R5/R6 read"}, r, er);
    end else begin
      chk(od == 0, {req, " R4 write oe"}, od, 0);
      if (sel && a >= 8'd1 && a <= 8'd4) mdl[a[2:0]] = d;
    end
    chk_cfg({req, " R11 cfg"});
  endtask

  initial begin
    logic [7:0] r, fc, fa, tmp; int oh, od;
    void'($urandom(32'd4242));
    for (int i = 1; i <= 4; i++) mdl[i] = 8'h00;
    wait_clk(5);
    // R12 reset state
    chk(mode == 16'h0 && dly == 16'h0, "R12 cfg reset", {mode, dly}, 0);
    chk(oe == 1'b0, "R12 oe reset", oe, 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk(oe == 1'b0, "R12 oe after reset", oe, 0);

    // R1 R5 R11 writes and read-back
    do_pkt(0, 0, 4'd0, 8'd1, 8'hA5, "R1 wr1");
    do_pkt(0, 0, 4'd0, 8'd2, 8'h3C, "R5 wr2");
    do_pkt(0, 0, 4'd0, 8'd3, 8'h81, "R5 wr3");
    do_pkt(0, 0, 4'd0, 8'd4, 8'h7E, "R5 wr4");
    for (int a = 1; a <= 4; a++) do_pkt(0, 1, 4'd0, 8'(a), 8'h00, "R1 rd");
    // R5 status read-only
    status = 8'hC3;
    do_pkt(0, 0, 4'd0, 8'd0, 8'hFF, "R5 wr status");
    do_pkt(0, 1, 4'd0, 8'd0, 8'h00, "R5 rd status");
    // R6 unmapped
    do_pkt(0, 0, 4'd0, 8'd7, 8'h11, "R6 wr unmapped");
    do_pkt(0, 1, 4'd0, 8'd9, 8'h00, "R6 rd unmapped");
    // R3 chain ID and broadcast, R2 id layout
    do_pkt(0, 0, 4'd3, 8'd1, 8'h55, "R3 other id");
    do_pkt(1, 0, 4'd5, 8'd2, 8'h99, "R3 bcast wr");
    do_pkt(0, 1, 4'd2, 8'd1, 8'h00, "R3 rd other");
    do_pkt(1, 1, 4'd1, 8'd1, 8'h00, "R3 bcast rd");
    do_pkt(0, 0, 4'd8, 8'd3, 8'h12, "R2 id8");
    do_pkt(0, 1, 4'd0, 8'd2, 8'h00, "R2 rd");

    // R9 short data byte, then lost until resync
    tmp = mdl[1];
    packet(mk_ctl(0, 0, 4'd0), 8'd1, 8'hEE, 5, r, fc, fa, oh, od);
    chk(mode[7:0] == tmp, "R9 short data", mode[7:0], tmp);
    packet(mk_ctl(0, 0, 4'd0), 8'd1, 8'hDD, 8, r, fc, fa, oh, od);
    chk(mode[7:0] == tmp, "R9 ignored while lost", mode[7:0], tmp);
    resync();
    do_pkt(0, 0, 4'd0, 8'd1, 8'h4B, "R8 after resync");

    // R10 overrun
    tmp = mdl[3];
    packet(mk_ctl(0, 0, 4'd0), 8'd3, 8'hF0, 10, r, fc, fa, oh, od);
    chk(dly[7:0] == tmp, "R10 overrun no commit", dly[7:0], tmp);
    resync();

    // R8 resync mid-packet
    send_byte(mk_ctl(0, 0, 4'd0), 8, r, fc, oh);
    send_byte(8'd3, 8, r, fa, oh);
    resync();
    do_pkt(0, 0, 4'd0, 8'd4, 8'h2D, "R8 mid-packet");
    chk(dly[7:0] == mdl[3], "R8 addr3 untouched", dly[7:0], mdl[3]);

    // random packets
    for (int k = 0; k < 80; k++) begin
      bit bc, rd; logic [3:0] id;
      bc = ($urandom % 4) == 0;
      rd = $urandom % 2;
      id = (($urandom % 3) == 0) ? 4'($urandom) : 4'd0;
      status = 8'($urandom);
      do_pkt(bc, rd, id, 8'($urandom % 8), 8'($urandom), "R1 rand");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule